// File: doc/BRIEF.md
# Systolic Tuple Intersection Array

This block tests every record of a relation A for membership in a relation B. A record is a group of NF fields, each FW bits wide. Field 0 sits in bits [FW-1:0] of a record word and field f in bits [f*FW +: FW]. The block is an array of 2N-1 rows by NF columns. Column f compares only field f. A records enter at the bottom row and climb one row per cycle. B records enter at the top row and descend one row per cycle. The field lanes are skewed inside the block, one cycle per column. As a result, a row compares one A record against one B record, field after field, on successive cycles.

Each cell passes on the AND of its incoming match flag and the bitwise equality of its field pair. Column 0 starts the chain with "both records present". At the last column, a row's result is ORed into a hit bit that travels with the A record. When an A record leaves the top of the array, the block emits the record's index together with that hit bit. Records are accepted only on alternate clock edges. This gap keeps the two opposing streams from slipping past each other between rows.

A batch is a set of at most N A records and at most N B records presented in N consecutive accept slots. Every A record of a batch meets every B record of that batch. Removing duplicates from one relation works the same way: the relation is fed as both A and B.

Top module: `tuple_isect`

## Requirements
- R1: While reset is high, and after its release until the first result, `res_valid` and `res_hit` are low.
- R2: Field f of a record occupies bits [f*FW +: FW]. An A record whose fields all equal the fields of some B record of its batch is reported with `res_hit`=1.
- R3: A single differing bit in any one field, the last field included, makes a pair a non-match. Every field is compared, and no partial match sets `res_hit`.
- R4: The first clock edge after reset release is an accept slot, and slots alternate with ignored edges from then on. When all records of a batch are presented in N consecutive slots, each A record meets each B record regardless of their order, including a pair that is N-1 slots apart.
- R5: `res_hit` is the OR over all B records met. Duplicate matches in B still give 1, and `res_hit` is never high without `res_valid`.
- R6: Each accepted A record produces exactly one result, in acceptance order, carrying its `a_idx`. The result appears NF+2N-3 clock edges after the accepting edge.
- R7: `a_valid` and `b_valid` presented on a non-slot edge have no effect, and no result follows from them.
- R8: When a relation is fed as both A and B, including records that repeat inside it, every A record reports `res_hit`=1.
- R9: `res_valid` is never high on two consecutive cycles.
- R10: With no common record, or with no B record at all, every A record is reported with `res_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | An A record is offered this cycle |
| a_idx | input | IW | Index tag of the offered A record |
| a_rec | input | NF*FW | Offered A record, field 0 in the low bits |
| b_valid | input | 1 | A B record is offered this cycle |
| b_rec | input | NF*FW | Offered B record, field 0 in the low bits |
| res_valid | output | 1 | An A record leaves the array this cycle |
| res_idx | output | IW | Index tag of the leaving A record |
| res_hit | output | 1 | The leaving A record matched at least one B record |

## Verification
The hardest case to reach from the ports is a pair that meets only in a corner row of the array. One example is the first A record of a batch against the last B record, which meet in the top row during the last column's cycle. A slot-parity slip or an off-by-one in the row range loses exactly that pair. The stimulus reaches it by placing the only matching B record N-1 slots after its A partner, in both directions. A second hard case is a difference confined to a single bit of the last field. The bench builds records that differ from a B record by one bit in each field position in turn.

// File: rtl/tuple_isect.sv
module tuple_isect #(
  parameter int FW = 8,
  parameter int NF = 4,
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            a_valid,
  input  logic [IW-1:0]   a_idx,
  input  logic [NF*FW-1:0] a_rec,
  input  logic            b_valid,
  input  logic [NF*FW-1:0] b_rec,
  output logic            res_valid,
  output logic [IW-1:0]   res_idx,
  output logic            res_hit
);
  localparam int ROWS = 2 * N - 1;

  logic phase;
  logic take_a, take_b;
  logic v0a [ROWS];
  logic v0b [ROWS];
  logic sk_va [NF-1];
  logic [IW-1:0] sk_idx [NF-1];
  logic va_l [ROWS];
  logic hit_l [ROWS];
  logic [IW-1:0] idx_l [ROWS];

  assign take_a = a_valid & ~phase;
  assign take_b = b_valid & ~phase;

  for (genvar f = 0; f < NF; f++) begin : col
    logic [FW-1:0] ina, inb;
    logic [FW-1:0] ar [ROWS];
    logic [FW-1:0] br [ROWS];
    logic tin  [ROWS];
    logic tout [ROWS];

    if (f == 0) begin : g_in
      assign ina = a_rec[FW-1:0];
      assign inb = b_rec[FW-1:0];
      always_comb
        for (int r = 0; r < ROWS; r++) tin[r] = v0a[r] & v0b[r];
    end else begin : g_in
      logic [FW-1:0] da [f];
      logic [FW-1:0] db [f];
      always_ff @(posedge clk) begin
        da[0] <= a_rec[f*FW +: FW];
        db[0] <= b_rec[f*FW +: FW];
        for (int k = 1; k < f; k++) begin
          da[k] <= da[k-1];
          db[k] <= db[k-1];
        end
      end
      assign ina = da[f-1];
      assign inb = db[f-1];
      always_comb
        for (int r = 0; r < ROWS; r++) tin[r] = col[f-1].g_m.m[r];
    end

    always_ff @(posedge clk) begin
      ar[0]      <= ina;
      br[ROWS-1] <= inb;
      for (int r = 1; r < ROWS; r++) ar[r] <= ar[r-1];
      for (int r = 0; r < ROWS - 1; r++) br[r] <= br[r+1];
    end

    always_comb
      for (int r = 0; r < ROWS; r++) tout[r] = tin[r] & (ar[r] == br[r]);

    if (f < NF - 1) begin : g_m
      logic m [ROWS];
      always_ff @(posedge clk)
        for (int r = 0; r < ROWS; r++) m[r] <= rst ? 1'b0 : tout[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        v0a[r] <= 1'b0; v0b[r] <= 1'b0; va_l[r] <= 1'b0; hit_l[r] <= 1'b0;
      end
      for (int k = 0; k < NF - 1; k++) sk_va[k] <= 1'b0;
    end else begin
      phase <= ~phase;
      v0a[0]      <= take_a;
      v0b[ROWS-1] <= take_b;
      for (int r = 1; r < ROWS; r++) v0a[r] <= v0a[r-1];
      for (int r = 0; r < ROWS - 1; r++) v0b[r] <= v0b[r+1];
      sk_va[0] <= take_a;
      for (int k = 1; k < NF - 1; k++) sk_va[k] <= sk_va[k-1];
      va_l[0]  <= sk_va[NF-2];
      hit_l[0] <= 1'b0;
      for (int r = 1; r < ROWS; r++) begin
        va_l[r]  <= va_l[r-1];
        hit_l[r] <= hit_l[r-1] | col[NF-1].tout[r-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    sk_idx[0] <= a_idx;
    for (int k = 1; k < NF - 1; k++) sk_idx[k] <= sk_idx[k-1];
    idx_l[0] <= sk_idx[NF-2];
    for (int r = 1; r < ROWS; r++) idx_l[r] <= idx_l[r-1];
  end

  assign res_valid = va_l[ROWS-1];
  assign res_idx   = idx_l[ROWS-1];
  assign res_hit   = hit_l[ROWS-1] | col[NF-1].tout[ROWS-1];

  a_r7_offslot_ignored: assert property (@(posedge clk) disable iff (rst)
    phase |=> (!v0a[0] && !v0b[ROWS-1]));

  a_r9_result_spacing: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  a_r5_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);

  for (genvar r = 0; r < ROWS - 1; r++) begin : g_chk
    a_r4_no_passby: assert property (@(posedge clk) disable iff (rst)
      !(v0a[r] && v0b[r+1]));
  end
endmodule

// File: tb/tuple_isect_bench.sv
module tuple_isect_bench;
  localparam int FW = 8, NF = 4, N = 4, IW = 2, RW = FW * NF;
  localparam int LAT = NF + 2 * N - 3;

  logic clk = 1'b0, rst = 1'b1;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic [IW-1:0] a_idx = '0;
  logic [RW-1:0] a_rec = '0, b_rec = '0;
  logic res_valid, res_hit;
  logic [IW-1:0] res_idx;

  tuple_isect #(.FW(FW), .NF(NF), .N(N), .IW(IW)) u_tuple_isect (
    .clk, .rst, .a_valid, .a_idx, .a_rec, .b_valid, .b_rec,
    .res_valid, .res_idx, .res_hit);

  always #5 clk = ~clk;

  int total = 0, bad = 0, ecnt = 0, got_n = 0, spacing_bad = 0;
  logic bphase = 1'b0, prev_v = 1'b0;
  int got_idx [16], got_lat [16], acc [N];
  logic got_hit [16];
  logic [RW-1:0] sa [N], sb [N];
  int na, nb;

  always @(posedge clk) begin
    ecnt <= ecnt + 1;
    bphase <= rst ? 1'b0 : ~bphase;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid && prev_v) spacing_bad++;
      if (res_valid && got_n < 16) begin
        got_idx[got_n] = int'(res_idx);
        got_hit[got_n] = res_hit;
        got_lat[got_n] = ecnt - acc[res_idx];
        got_n++;
      end
      prev_v = res_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expect_hit(input int i);
    for (int j = 0; j < nb; j++) if (sb[j] == sa[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_batch(input string req);
    got_n = 0;
    while (bphase != 1'b0) @(negedge clk);
    for (int k = 0; k < N; k++) begin
      a_valid = (k < na); a_idx = IW'(k); a_rec = sa[k];
      b_valid = (k < nb); b_rec = sb[k];
      acc[k] = ecnt + 1;
      @(negedge clk); @(negedge clk);
    end
    a_valid = 1'b0; b_valid = 1'b0;
    repeat (LAT + 2 * N) @(negedge clk);
    chk(got_n == na, "R6 count", got_n, na);
    for (int i = 0; i < got_n && i < na; i++) begin
      chk(got_idx[i] == i, "R6 order", got_idx[i], i);
      chk(got_lat[i] == LAT, "R6 latency", got_lat[i], LAT);
      chk(got_hit[i] == expect_hit(i), req, int'(got_hit[i]), int'(expect_hit(i)));
    end
  endtask

  task automatic t_basic;
    na = 4; nb = 4;
    sa = '{32'h11223344, 32'hAABBCCDD, 32'h01020304, 32'hDEADBEEF};
    sb = '{32'h01020304, 32'h12345678, 32'h11223344, 32'h00000000};
    run_batch("R2 full match");
  endtask

  task automatic t_onefield;
    logic [RW-1:0] x = 32'hC0DEF00D;
    na = 4; nb = 4;
    sa = '{x ^ 32'h00000001, x ^ 32'h00000100, x ^ 32'h00010000, x ^ 32'h80000000};
    sb = '{x, x ^ 32'h00000003, x ^ 32'h00FF0000, x ^ 32'h01000000};
    run_batch("R3 one field differs");
  endtask

  task automatic t_far_dup;
    logic [RW-1:0] p = 32'h5A5A0001, q = 32'h5A5A0002, r = 32'h77000077;
    na = 4; nb = 4;
    sa = '{p, q, r, 32'h0BADCAFE};
    sb = '{32'h0BADCAFE, r, 32'h99999999, p};
    run_batch("R4 far pair");
    sa = '{p, q, r, p};
    sb = '{q, q, r, q};
    run_batch("R5 duplicate B");
  endtask

  task automatic t_self;
    na = 4; nb = 4;
    sa = '{32'h10203040, 32'h50607080, 32'h10203040, 32'hFFFFFFFF};
    sb = sa;
    run_batch("R8 self intersection");
    for (int i = 0; i < na; i++) chk(got_hit[i] == 1'b1, "R8 all hit", int'(got_hit[i]), 1);
  endtask

  task automatic t_none;
    na = 4; nb = 4;
    sa = '{32'h00000001, 32'h00000002, 32'h00000003, 32'h00000004};
    sb = '{32'h00000010, 32'h00000020, 32'h00000030, 32'h00000040};
    run_batch("R10 no overlap");
    na = 2; nb = 0;
    run_batch("R10 empty B");
  endtask

  task automatic t_offslot;
    got_n = 0;
    while (bphase != 1'b1) @(negedge clk);
    a_valid = 1'b1; a_idx = '0; a_rec = 32'h13572468;
    b_valid = 1'b1; b_rec = 32'h13572468;
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
    repeat (LAT + 2 * N) @(negedge clk);
    chk(got_n == 0, "R7 off-slot ignored", got_n, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0 && res_hit == 1'b0, "R1 in reset", int'(res_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0 && res_hit == 1'b0, "R1 after reset", int'(res_valid), 0);
    t_basic();
    t_onefield();
    t_far_dup();
    t_self();
    t_none();
    t_offslot();
    chk(spacing_bad == 0, "R9 spacing", spacing_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule